// File: doc/BRIEF.md
# Exception Vector Window Remapper

This block sits in front of the memory address decoder and translates every CPU address before decode. The lowest 64 bytes of the address space form a window. That window holds the eight one-word exception vectors from 0x00 to 0x1C and 32 further bytes for literal constants. The window can be served from one of four source regions: the boot block, the user flash, the on-chip SRAM or external memory. A 2-bit source select register chooses the region. Software writes this register through a write strobe.

Only the window moves. Every other address reaches the decoder unchanged in every mode. This means a source region can still be reached at its own home address as well as through address zero. With the default parameters the user flash sits at address zero, so the flash mode is an identity mapping. A handler that starts at 0x1C can therefore run straight past the end of the window.

The result is registered. A translated address appears one clock after the CPU address is presented, together with a valid flag and a flag that marks a window hit.

Top module: `vector_remap_unit`

## Requirements
- R1: After synchronous reset, `out_valid` is 0 and the source select is boot block (code 2'b00). A window access made right after reset is translated to `BOOT_BASE`.
- R2: `out_valid` equals the `in_valid` of the previous clock. When `in_valid` was 1, `out_addr` and `out_win` describe the address presented in that previous clock.
- R3: With source code 2'b00 (boot block), an address in 0x00..0x3F translates to `BOOT_BASE + addr[5:0]`.
- R4: With source code 2'b01 (user flash), an address in 0x00..0x3F translates to `FLASH_BASE + addr[5:0]`. With the default `FLASH_BASE` of 0 this is the address itself.
- R5: With source code 2'b10 (SRAM), an address in 0x00..0x3F translates to `SRAM_BASE + addr[5:0]`.
- R6: With source code 2'b11 (external), an address in 0x00..0x3F translates to `EXT_BASE + addr[5:0]`.
- R7: Any address at or above 0x40 passes through unchanged in every mode. 0x3F is the last remapped byte and 0x40 is the first unchanged one.
- R8: A source region stays reachable at its home address. For example, `BOOT_BASE + 4` is output unchanged whatever the mode.
- R9: A write to the source select changes only accesses presented in later clocks. An access presented in the same clock as the write uses the old source.
- R10: While `in_valid` is 0, `out_addr` and `out_win` hold their previous values.
- R11: `out_win` is 1 exactly when the translated access fell inside the 64-byte window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_we | input | 1 | Write strobe for the source select register |
| sel_wdata | input | 2 | New source code: 00 boot, 01 flash, 10 SRAM, 11 external |
| in_valid | input | 1 | CPU address is valid this clock |
| in_addr | input | ADDR_W | CPU byte address |
| out_valid | output | 1 | Registered valid, one clock after `in_valid` |
| out_addr | output | ADDR_W | Registered translated address |
| out_win | output | 1 | Registered flag: the access hit the remap window |

## Verification
Every translation is due exactly one clock after its address is presented. A change of source select affects addresses presented from the clock after the write onward.

The bench drives inputs on the falling edge and waits through one rising edge. It then samples on the next falling edge and compares against a model. The model uses the source code that was in force before any write made in the same clock, and only then applies that write.

Idle clocks are checked for held outputs. The 0x3F/0x40 boundary, the home addresses and a same-clock write with access are driven directly, and random traffic is mixed in with them.

// File: rtl/vrm_pkg.sv
package vrm_pkg;
  typedef enum logic [1:0] {
    SRC_BOOT  = 2'b00,
    SRC_FLASH = 2'b01,
    SRC_SRAM  = 2'b10,
    SRC_EXT   = 2'b11
  } src_e;
endpackage

// File: rtl/vrm_sel_reg.sv
module vrm_sel_reg
  import vrm_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       we,
  input  logic [1:0] wdata,
  output src_e       sel
);
  // R9: new source is visible only after the clock edge that captures it
  always_ff @(posedge clk) begin
    if (rst)     sel <= SRC_BOOT;
    else if (we) sel <= src_e'(wdata);
  end
endmodule

// File: rtl/vrm_xlate.sv
module vrm_xlate
  import vrm_pkg::*;
#(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned WIN_BITS = 6,
  parameter logic [ADDR_W-1:0] BOOT_BASE  = 32'h7FFF_E000,
  parameter logic [ADDR_W-1:0] FLASH_BASE = 32'h0000_0000,
  parameter logic [ADDR_W-1:0] SRAM_BASE  = 32'h4000_0000,
  parameter logic [ADDR_W-1:0] EXT_BASE   = 32'h8000_0000
) (
  input  src_e              sel,
  input  logic [ADDR_W-1:0] addr,
  output logic [ADDR_W-1:0] xaddr,
  output logic              hit
);
  localparam int unsigned HI_W = ADDR_W - WIN_BITS;

  logic [ADDR_W-1:0] base;
  logic [ADDR_W-1:0] offs;

  always_comb begin
    unique case (sel)
      SRC_BOOT:  base = BOOT_BASE;
      SRC_FLASH: base = FLASH_BASE;
      SRC_SRAM:  base = SRAM_BASE;
      default:   base = EXT_BASE;
    endcase
    offs  = {{HI_W{1'b0}}, addr[WIN_BITS-1:0]};
    hit   = (addr[ADDR_W-1:WIN_BITS] == '0);
    xaddr = hit ? (base + offs) : addr;
  end
endmodule

// File: rtl/vector_remap_unit.sv
module vector_remap_unit
  import vrm_pkg::*;
#(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned WIN_BITS = 6,
  parameter logic [ADDR_W-1:0] BOOT_BASE  = 32'h7FFF_E000,
  parameter logic [ADDR_W-1:0] FLASH_BASE = 32'h0000_0000,
  parameter logic [ADDR_W-1:0] SRAM_BASE  = 32'h4000_0000,
  parameter logic [ADDR_W-1:0] EXT_BASE   = 32'h8000_0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_we,
  input  logic [1:0]        sel_wdata,
  input  logic              in_valid,
  input  logic [ADDR_W-1:0] in_addr,
  output logic              out_valid,
  output logic [ADDR_W-1:0] out_addr,
  output logic              out_win
);
  src_e              sel_q;
  logic [ADDR_W-1:0] x_addr;
  logic              x_hit;

  vrm_sel_reg u_sel (
    .clk   (clk),
    .rst   (rst),
    .we    (sel_we),
    .wdata (sel_wdata),
    .sel   (sel_q)
  );

  vrm_xlate #(
    .ADDR_W     (ADDR_W),
    .WIN_BITS   (WIN_BITS),
    .BOOT_BASE  (BOOT_BASE),
    .FLASH_BASE (FLASH_BASE),
    .SRAM_BASE  (SRAM_BASE),
    .EXT_BASE   (EXT_BASE)
  ) u_xlate (
    .sel   (sel_q),
    .addr  (in_addr),
    .xaddr (x_addr),
    .hit   (x_hit)
  );

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else     out_valid <= in_valid;
  end

  // data path without reset so it maps to plain flops
  always_ff @(posedge clk) begin
    if (in_valid) begin
      out_addr <= x_addr;
      out_win  <= x_hit;
    end
  end
endmodule

// File: rtl/vector_remap_unit_chk.sv
module vector_remap_unit_chk #(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned WIN_BITS = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [ADDR_W-1:0] in_addr,
  input logic              out_valid,
  input logic [ADDR_W-1:0] out_addr,
  input logic              out_win
);
  p_reset_idle_r1: assert property (@(posedge clk) rst |=> !out_valid);

  p_valid_follow_r2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  p_idle_follow_r2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  p_outside_pass_r7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_addr[ADDR_W-1:WIN_BITS] != '0) |=>
      (out_addr == $past(in_addr) && !out_win));

  p_window_flag_r11: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_addr[ADDR_W-1:WIN_BITS] == '0) |=> out_win);

  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !in_valid) |=> ($stable(out_addr) && $stable(out_win)));
endmodule

bind vector_remap_unit vector_remap_unit_chk #(
  .ADDR_W   (ADDR_W),
  .WIN_BITS (WIN_BITS)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_addr   (in_addr),
  .out_valid (out_valid),
  .out_addr  (out_addr),
  .out_win   (out_win)
);

// File: tb/tb_vector_remap_unit.sv
module tb_vector_remap_unit;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] B_BOOT  = 32'h7FFF_E000;
  localparam logic [31:0] B_FLASH = 32'h0000_0000;
  localparam logic [31:0] B_SRAM  = 32'h4000_0000;
  localparam logic [31:0] B_EXT   = 32'h8000_0000;

  logic        clk = 0;
  logic        rst = 1;
  logic        sel_we = 0;
  logic [1:0]  sel_wdata = 0;
  logic        in_valid = 0;
  logic [31:0] in_addr = 0;
  logic        out_valid;
  logic [31:0] out_addr;
  logic        out_win;

  int n_chk = 0, n_bad = 0;
  logic [1:0]  m_sel = 2'b00;
  logic [31:0] last_addr = 0;
  logic        last_win = 0;

  vector_remap_unit dut (
    .clk(clk), .rst(rst), .sel_we(sel_we), .sel_wdata(sel_wdata),
    .in_valid(in_valid), .in_addr(in_addr),
    .out_valid(out_valid), .out_addr(out_addr), .out_win(out_win)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] f_base(input logic [1:0] s);
    case (s)
      2'b00:   return B_BOOT;
      2'b01:   return B_FLASH;
      2'b10:   return B_SRAM;
      default: return B_EXT;
    endcase
  endfunction

  function automatic logic [31:0] f_xlate(input logic [1:0] s, input logic [31:0] a);
    if (a[31:6] == 0) return f_base(s) + {26'd0, a[5:0]};
    return a;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one clock: drive at falling edge, sample at next falling edge
  task automatic cyc(input string req, input logic v, input logic [31:0] a,
                     input logic we, input logic [1:0] wd);
    logic [31:0] e_addr;
    logic        e_win;
    in_valid = v; in_addr = a; sel_we = we; sel_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    if (v) begin
      e_addr = f_xlate(m_sel, a);
      e_win  = (a[31:6] == 0);
      last_addr = e_addr; last_win = e_win;
    end else begin
      e_addr = last_addr; e_win = last_win;
    end
    chk({req, " valid"}, {31'd0, out_valid}, {31'd0, v});
    chk({req, " addr"}, out_addr, e_addr);
    chk({req, " win"}, {31'd0, out_win}, {31'd0, e_win});
    if (we) m_sel = wd;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk);
    @(negedge clk);
    chk("R1 reset valid", {31'd0, out_valid}, 32'd0);
    rst = 0;
    // R1: boot source after reset
    cyc("R1/R3 boot vec0", 1, 32'h0, 0, 0);
    cyc("R3 boot 0x1C", 1, 32'h1C, 0, 0);
    cyc("R7 boot 0x3F", 1, 32'h3F, 0, 0);
    cyc("R7 boot 0x40", 1, 32'h40, 0, 0);
    cyc("R8 boot home", 1, B_BOOT + 4, 0, 0);
    cyc("R10 idle hold", 0, 32'hDEAD_BEEF, 0, 0);
    cyc("R10 idle hold2", 0, 32'h4, 0, 0);
    // R9: write with access in same clock uses old source
    cyc("R9 same-clock write", 1, 32'h18, 1, 2'b10);
    cyc("R5 sram window", 1, 32'h18, 0, 0);
    cyc("R8 sram home", 1, B_SRAM + 32'h18, 0, 0);
    cyc("R9 switch to flash", 0, 0, 1, 2'b01);
    cyc("R4 flash 0x1C", 1, 32'h1C, 0, 0);
    cyc("R4 flash 0x3C", 1, 32'h3C, 0, 0);
    cyc("R6 switch ext", 1, 32'h8, 1, 2'b11);
    cyc("R6 ext window", 1, 32'h8, 0, 0);
    cyc("R7 ext outside", 1, 32'hE000_C000, 0, 0);
    cyc("R8 ext home", 1, B_EXT + 32'h20, 0, 0);
    cyc("R2 valid drop", 0, 32'h0, 0, 0);
    for (int i = 0; i < 600; i++) begin
      logic        v, we;
      logic [1:0]  wd;
      logic [31:0] a;
      v  = ($urandom % 4) != 0;
      we = ($urandom % 6) == 0;
      wd = 2'($urandom);
      a  = ($urandom % 2) ? {26'd0, 6'($urandom)} : $urandom;
      cyc("R2-rand R11", v, a, we, wd);
    end
    rst = 1;
    @(negedge clk);
    rst = 0;
    m_sel = 2'b00;
    cyc("R1 boot after re-reset", 1, 32'h4, 0, 0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule